// File: doc/BRIEF.md
# Operand Latency Scoreboard

This block tracks, for an in-order integer pipeline, how many more cycles each architectural register's pending result needs before a given kind of consumer may read it. Registers 0 to 31 are the general registers, index 32 is the multiply-high register and index 33 is the multiply-low register. When an instruction issues, its producer class is presented together with its destination. From then on, every tracked register keeps one down-counter per consumer use.

A candidate instruction presents up to two source operands. Each operand carries a use code that says how the consumer reads it: as an execute operand, as a load/store address, as store data, or as a multiply/divide accumulator input. The block raises `stall` in the same cycle while any operand's counter for that use is still nonzero.

Two further hazards share the same stall output. A 64-bit multiply blocks another multiply from issuing in the following cycle. A load that depends through memory on the latest store must wait for that store's forwarding window. The block models one issue per cycle and holds no data.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset no hazard is pending, and `stall` is 0 for any candidate.
- R2: Timing convention for all latencies. A latency of L cycles means a dependent candidate stalls in the L-1 cycles that follow the issue edge. Latencies of 0 and 1 cause no stall. Producer class 1 (ALU) has latency 5 to address use (code 2) and latency 1 to execute (1), store data (3) and multiply/divide (4) uses.
- R3: Producer class 2 (load) has latency 3 to address use, 0 to store-data use, and 1 to execute and multiply/divide uses.
- R4: Producer classes 3 (32-bit multiply) and 4 (64-bit multiply) write index 32 and index 33 and ignore the destination input. Their latency to address and store-data uses is 7. For execute and multiply/divide uses, class 3 has latency 3 on both registers, and class 4 has latency 3 on index 33 and 4 on index 32.
- R5: After a class 4 issue, a candidate with `cand_is_mul`=1 stalls in exactly the next cycle. A class 3 issue causes no such block.
- R6: Producer class 5 (move to hi/lo) writes its destination only when the destination is 32 or 33. It has latency 3 to execute use and 4 to every other use.
- R7: Producer class 6 (floating-to-integer transfer) has latency 1 to every use.
- R8: Producer class 7 (store) writes no register. A candidate with `cand_mem_dep`=1 waits 5 cycles after the store, which means 4 stalled cycles.
- R9: Writes to index 0, and to indices above 33, are never tracked. Classes 0 (untracked) never create a hazard.
- R10: A new producer for a register replaces that register's remaining counts with the new class's values.
- R11: Use code 0 means the slot is unused and is ignored. A hazard on either source slot asserts `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_cls | input | 3 | Producer class of the issuing instruction |
| iss_dst | input | IW | Destination register index |
| cand_src | input | NSRC*IW | Candidate source indices, slot s at bits s*IW upward |
| cand_use | input | NSRC*3 | Candidate use codes, slot s at bits s*3 upward |
| cand_is_mul | input | 1 | Candidate is a multiply |
| cand_mem_dep | input | 1 | Candidate load depends on the latest store through memory |
| stall | output | 1 | Candidate must not issue this cycle |

## Verification
A counter that is loaded wrongly or decays wrongly shows up directly as `stall` staying high for the wrong number of cycles after the producer issues. The error is visible within at most six cycles of the issue. Because every latency is observed as a run length of `stall`, each class-by-use pair is measured separately. This catches off-by-one loads, wrong hi/lo selection and a missed reload. Untracked writes are checked by reading the same index afterwards and confirming that `stall` stays low.

// File: rtl/lat_scoreboard.sv
`timescale 1ns/1ps
module lat_scoreboard #(
  parameter int NSRC = 2,
  parameter int IW   = 6,
  parameter int CW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [2:0]         iss_cls,
  input  logic [IW-1:0]      iss_dst,
  input  logic [NSRC*IW-1:0] cand_src,
  input  logic [NSRC*3-1:0]  cand_use,
  input  logic               cand_is_mul,
  input  logic               cand_mem_dep,
  output logic               stall
);
  localparam int NREG = 34;
  localparam int HI   = 32;
  localparam int LO   = 33;
  localparam int NUSE = 4;
  localparam int MEMW = 5;

  localparam logic [2:0] C_ALU = 3'd1, C_LD = 3'd2, C_M32 = 3'd3, C_M64 = 3'd4,
                         C_MT = 3'd5, C_FX = 3'd6, C_ST = 3'd7;

  logic [CW-1:0] cnt [NREG][NUSE];
  logic [CW-1:0] memc;
  logic          mblk;
  logic [NREG-1:0] wr;

  function automatic logic [3:0] lat(input logic [2:0] c, input int u, input bit is_hi);
    bit mem_use;
    mem_use = (u == 1) || (u == 2);
    case (c)
      C_ALU:   lat = (u == 1) ? 4'd5 : 4'd1;
      C_LD:    lat = (u == 1) ? 4'd3 : (u == 2) ? 4'd0 : 4'd1;
      C_M32:   lat = mem_use ? 4'd7 : 4'd3;
      C_M64:   lat = mem_use ? 4'd7 : (is_hi ? 4'd4 : 4'd3);
      C_MT:    lat = (u == 0) ? 4'd3 : 4'd4;
      C_FX:    lat = 4'd1;
      default: lat = 4'd0;
    endcase
  endfunction

  always_comb begin
    wr = '0;
    if (iss_valid) begin
      for (int r = 1; r < NREG; r++) begin
        case (iss_cls)
          C_ALU, C_LD, C_FX: wr[r] = (int'(iss_dst) == r) && (r < HI);
          C_M32, C_M64:      wr[r] = (r == HI) || (r == LO);
          C_MT:              wr[r] = (int'(iss_dst) == r) && (r >= HI);
          default:           wr[r] = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int u = 0; u < NUSE; u++) cnt[r][u] <= '0;
      memc <= '0;
      mblk <= 1'b0;
    end else begin
      for (int r = 0; r < NREG; r++)
        for (int u = 0; u < NUSE; u++) begin
          if (wr[r]) begin
            logic [3:0] l;
            l = lat(iss_cls, u, r == HI);
            cnt[r][u] <= (l == 4'd0) ? '0 : CW'(l - 4'd1);
          end else if (cnt[r][u] != '0) begin
            cnt[r][u] <= cnt[r][u] - 1'b1;
          end
        end
      if (iss_valid && iss_cls == C_ST) memc <= CW'(MEMW - 1);
      else if (memc != '0)              memc <= memc - 1'b1;
      mblk <= iss_valid && iss_cls == C_M64;
    end
  end

  logic src_hz;
  logic any_use;
  always_comb begin
    src_hz  = 1'b0;
    any_use = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      logic [IW-1:0] idx;
      logic [2:0]    uc;
      idx = cand_src[s*IW +: IW];
      uc  = cand_use[s*3 +: 3];
      if (uc != 3'd0) any_use = 1'b1;
      if (uc >= 3'd1 && uc <= 3'd4 && int'(idx) < NREG)
        if (cnt[int'(idx)][int'(uc) - 1] != '0) src_hz = 1'b1;
    end
  end

  assign stall = src_hz || (cand_mem_dep && memc != '0) || (cand_is_mul && mblk);

  assert_mul_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == C_M64) |=> (!cand_is_mul || stall));
  assert_store_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == C_ST) |=> (!cand_mem_dep || stall));
  assert_mem_decay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(iss_valid && iss_cls == C_ST) && memc != '0) |=> (memc == $past(memc) - 1'b1));
  assert_r0_untracked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_dst == '0 && iss_cls != C_MT) |=> (cnt[0][0] == '0 && cnt[0][1] == '0));
  assert_idle_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_use && !cand_is_mul && !cand_mem_dep) |-> !stall);
  assert_hi_decay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr[HI] && cnt[HI][1] != '0) |=> (cnt[HI][1] == $past(cnt[HI][1]) - 1'b1));
endmodule

// File: tb/test_lat_scoreboard.sv
`timescale 1ns/1ps
module test_lat_scoreboard;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0;
  logic [2:0] iss_cls = 0;
  logic [5:0] iss_dst = 0;
  logic [11:0] cand_src = 0;
  logic [5:0] cand_use = 0;
  logic cand_is_mul = 0, cand_mem_dep = 0;
  logic stall;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  lat_scoreboard i_lat_scoreboard (.clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
    .iss_cls(iss_cls), .iss_dst(iss_dst), .cand_src(cand_src), .cand_use(cand_use),
    .cand_is_mul(cand_is_mul), .cand_mem_dep(cand_mem_dep), .stall(stall));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cand(input [5:0] src, input [2:0] use_c, input bit slot1, input bit mul, input bit md);
    cand_src = slot1 ? {src, 6'd0} : {6'd0, src};
    cand_use = slot1 ? {use_c, 3'd0} : {3'd0, use_c};
    cand_is_mul = mul;
    cand_mem_dep = md;
  endtask

  task automatic measure(output int n);
    n = 0;
    #1;
    while (stall && n < 20) begin n++; @(negedge clk); #1; end
  endtask

  task automatic clear_wait();
    set_cand(0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic run(input [2:0] cls, input [5:0] dst, input [5:0] src, input [2:0] use_c,
                     input bit slot1, input bit mul, input bit md, input int exp, input string tag);
    int n;
    @(negedge clk);
    iss_valid = 1; iss_cls = cls; iss_dst = dst;
    @(negedge clk);
    iss_valid = 0;
    set_cand(src, use_c, slot1, mul, md);
    measure(n);
    check(n == exp, tag, n, exp);
    clear_wait();
  endtask

  function automatic int stalls_of(input int lat_v);
    return (lat_v > 1) ? lat_v - 1 : 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    set_cand(6'd32, 3'd2, 0, 1, 1);
    cand_use = {3'd1, 3'd2};
    cand_src = {6'd33, 6'd32};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(stall == 0, "R1 reset state", stall, 0);
    clear_wait();

    for (int u = 1; u <= 4; u++) begin
      run(3'd1, 6'd5, 6'd5, 3'(u), u[0], 0, 0, stalls_of(u == 2 ? 5 : 1), $sformatf("R2 alu use%0d", u));
      run(3'd2, 6'd7, 6'd7, 3'(u), 0, 0, 0, stalls_of(u == 2 ? 3 : (u == 3 ? 0 : 1)), $sformatf("R3 load use%0d", u));
      run(3'd3, 6'd9, 6'd32, 3'(u), 0, 0, 0, stalls_of((u == 2 || u == 3) ? 7 : 3), $sformatf("R4 mul32 hi use%0d", u));
      run(3'd3, 6'd9, 6'd33, 3'(u), 1, 0, 0, stalls_of((u == 2 || u == 3) ? 7 : 3), $sformatf("R4 mul32 lo use%0d", u));
      run(3'd4, 6'd9, 6'd32, 3'(u), 0, 0, 0, stalls_of((u == 2 || u == 3) ? 7 : 4), $sformatf("R4 mul64 hi use%0d", u));
      run(3'd4, 6'd9, 6'd33, 3'(u), 0, 0, 0, stalls_of((u == 2 || u == 3) ? 7 : 3), $sformatf("R4 mul64 lo use%0d", u));
      run(3'd5, 6'd33, 6'd33, 3'(u), 0, 0, 0, stalls_of(u == 1 ? 3 : 4), $sformatf("R6 mthilo use%0d", u));
      run(3'd6, 6'd11, 6'd11, 3'(u), 0, 0, 0, 0, $sformatf("R7 fxfer use%0d", u));
    end

    run(3'd4, 6'd0, 6'd0, 3'd0, 0, 1, 0, 1, "R5 mul64 blocks next multiply");
    run(3'd3, 6'd0, 6'd0, 3'd0, 0, 1, 0, 0, "R5 mul32 no block");
    run(3'd5, 6'd4, 6'd4, 3'd1, 0, 0, 0, 0, "R6 mthilo to gpr ignored");
    run(3'd7, 6'd3, 6'd0, 3'd0, 0, 0, 1, 4, "R8 store to dependent load");
    run(3'd7, 6'd3, 6'd3, 3'd2, 0, 0, 0, 0, "R8 store writes no register");
    run(3'd1, 6'd0, 6'd0, 3'd2, 0, 0, 0, 0, "R9 r0 untracked");
    run(3'd1, 6'd40, 6'd40, 3'd2, 0, 0, 0, 0, "R9 index above 33 ignored");
    run(3'd0, 6'd6, 6'd6, 3'd2, 0, 0, 0, 0, "R9 class 0 untracked");
    run(3'd1, 6'd3, 6'd3, 3'd0, 0, 0, 0, 0, "R11 use none ignored");
    run(3'd1, 6'd3, 6'd3, 3'd2, 1, 0, 0, 4, "R11 hazard in slot 1");

    @(negedge clk);
    iss_valid = 1; iss_cls = 3'd1; iss_dst = 6'd12;
    @(negedge clk);
    iss_cls = 3'd2;
    @(negedge clk);
    iss_valid = 0;
    set_cand(6'd12, 3'd2, 0, 0, 0);
    measure(n);
    check(n == 2, "R10 reload replaces counts", n, 2);
    clear_wait();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule